// File: doc/BRIEF.md
# PM1 Event and Enable Register Block

This block holds a pair of 16-bit power-management event registers, a status register and an enable register, behind a four-byte I/O window. Byte offsets 0 and 1 reach the status register (low byte, then high byte) and offsets 2 and 3 reach the enable register. An access is 1, 2 or 4 bytes wide and is split into byte lanes, all of which are applied in the same clock cycle.

Three single-cycle event inputs set status bits: a timer status pulse, a power button press and a sleep button press. Software clears status bits by writing ones to them and arms them by setting the matching enable bits. The block drives a level-sensitive system control interrupt that stays high while any armed event bit in a fixed mask is pending. Reads are combinational from the current register contents and the access offset and size.

Top module: `pm1_evt_regs`

## Requirements
- R1: A high `tmr_evt` sets status bit 0, a high `pwr_evt` sets status bit 8 and a high `slp_evt` sets status bit 9, all on the next rising clock edge; the enable register uses the same bit positions.
- R2: `sci_level` is high exactly while (enable AND status AND mask) is nonzero, where the mask holds bits 0, 5, 8 and 9; it follows the registers, so it changes in the cycle after the write or event that changes them.
- R3: A write lane at offset 0 clears each status bit of [7:0], and a lane at offset 1 each bit of [15:8], whose data bit is 1; status bits written as 0 keep their value.
- R4: No write ever sets a status bit; status bits become 1 only through the event inputs.
- R5: A write lane at offset 2 replaces enable[7:0] and a lane at offset 3 replaces enable[15:8]; the other enable byte is unchanged.
- R6: `acc_size` 2'b00 means 1 byte, 2'b01 means 2 bytes, 2'b10 and 2'b11 mean 4 bytes. Data byte k (bits 8k+7:8k) goes to offset `acc_offset`+k; bytes that fall beyond offset 3 are dropped.
- R7: `rd_data` equals the word {enable, status} shifted right by 8 times `acc_offset`, then zero-extended from 8 bits for a 1-byte size and from 16 bits for a 2-byte size.
- R8: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R9: Reset (active-low `rst_n`) clears both registers to zero and holds `sci_level` low.
- R10: An access with `acc_write` low, or with `acc_valid` low, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 2 | Byte offset inside the window |
| acc_size | input | 2 | Access size code (see R6) |
| acc_wdata | input | 32 | Write data, least significant byte first |
| tmr_evt | input | 1 | Timer status event pulse |
| pwr_evt | input | 1 | Power button event pulse |
| slp_evt | input | 1 | Sleep button event pulse |
| rd_data | output | 32 | Read data for the current offset and size |
| sci_level | output | 1 | Level system control interrupt |

## Verification
The bench drives 4-byte writes starting at offset 3, where a design that wraps lanes instead of dropping them would corrupt the status register, and 2-byte accesses starting at offset 1 that straddle the two registers, where a lane swap shows as the wrong enable byte. It writes zeros to pending status bits and collides a sleep event with a clear of the same bit, which catch a plain-store status register and a clear-wins priority. Enabling only the global bit with the timer bit pending checks the mask, and reads with odd offsets and every size code catch shift or width errors in read assembly.

// File: rtl/pm1_evt_pkg.sv
package pm1_evt_pkg;
    localparam int BYTE_W    = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = LANES * BYTE_W;
    localparam int REG_W     = 16;
    localparam int REG_BYTES = REG_W / BYTE_W;
    localparam int OFF_W     = $clog2(LANES);

    localparam int BIT_TMR = 0;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_SLP = 9;

    localparam logic [REG_W-1:0] SCI_MASK =
        (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GBL) |
        (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_SLP);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;
endpackage

// File: rtl/pm1_lane_decode.sv
module pm1_lane_decode
    import pm1_evt_pkg::*;
(
    input  logic                             wr_stb,
    input  logic [OFF_W-1:0]                 offset,
    input  logic [1:0]                       size,
    input  logic [WORD_W-1:0]                wdata,
    output logic [LANES-1:0]                 lane_we,
    output logic [LANES-1:0][BYTE_W-1:0]     lane_byte
);
    logic [OFF_W:0] nbytes;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = (OFF_W+1)'(1);
            SZ_HALF: nbytes = (OFF_W+1)'(2);
            default: nbytes = (OFF_W+1)'(LANES);
        endcase
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [OFF_W:0] LANE_IDX = (OFF_W+1)'(j);
        logic [OFF_W:0]  rel;
        logic [WORD_W-1:0] shifted;

        assign rel     = LANE_IDX - {1'b0, offset};
        assign shifted = wdata >> (BYTE_W * int'(rel[OFF_W-1:0]));
        assign lane_we[j]   = wr_stb && !rel[OFF_W] && (rel < nbytes);
        assign lane_byte[j] = shifted[BYTE_W-1:0];
    end
endmodule

// File: rtl/pm1_status_reg.sv
module pm1_status_reg
    import pm1_evt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [REG_BYTES-1:0]              clr_we,
    input  logic [REG_BYTES-1:0][BYTE_W-1:0]  clr_byte,
    input  logic [REG_W-1:0]                  set_vec,
    output logic [REG_W-1:0]                  sts_q
);
    logic [REG_W-1:0] clr_mask;

    for (genvar b = 0; b < REG_BYTES; b++) begin : g_clr
        assign clr_mask[b*BYTE_W +: BYTE_W] = clr_we[b] ? clr_byte[b] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_mask) | set_vec;
    end

    // R8
    sts_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

    // R4
    sts_no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts_q & ~$past(sts_q) & ~$past(set_vec)) == '0));

    // R3
    sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_we) |=> ((sts_q & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/pm1_enable_reg.sv
module pm1_enable_reg
    import pm1_evt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [REG_BYTES-1:0]              wr_we,
    input  logic [REG_BYTES-1:0][BYTE_W-1:0]  wr_byte,
    output logic [REG_W-1:0]                  en_q
);
    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        en_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_we[b]) en_q[b*BYTE_W +: BYTE_W] <= wr_byte[b];
        end

        // R5
        en_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_we[b] |=> $stable(en_q[b*BYTE_W +: BYTE_W]));

        // R5
        en_lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_we[b] |=> (en_q[b*BYTE_W +: BYTE_W] == $past(wr_byte[b])));
    end
endmodule

// File: rtl/pm1_read_mux.sv
module pm1_read_mux
    import pm1_evt_pkg::*;
(
    input  logic [REG_W-1:0]  sts,
    input  logic [REG_W-1:0]  en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] shifted;

    assign shifted = {en, sts} >> (BYTE_W * int'(offset));

    always_comb begin
        unique case (size)
            SZ_BYTE: rd_data = {{(WORD_W-BYTE_W){1'b0}}, shifted[BYTE_W-1:0]};
            SZ_HALF: rd_data = {{(WORD_W-REG_W){1'b0}}, shifted[REG_W-1:0]};
            default: rd_data = shifted;
        endcase
    end

    // R7
    always_comb begin
        if (size == SZ_BYTE) begin
            rd_byte_width_chk: assert (rd_data[WORD_W-1:BYTE_W] == '0);
        end
    end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
    import pm1_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_offset,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    input  logic              tmr_evt,
    input  logic              pwr_evt,
    input  logic              slp_evt,
    output logic [31:0]       rd_data,
    output logic              sci_level
);
    logic                          wr_stb;
    logic [LANES-1:0]              lane_we;
    logic [LANES-1:0][BYTE_W-1:0]  lane_byte;
    logic [REG_W-1:0]              set_vec;
    logic [REG_W-1:0]              sts_q;
    logic [REG_W-1:0]              en_q;

    assign wr_stb = acc_valid && acc_write;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_TMR] = tmr_evt;
        set_vec[BIT_PWR] = pwr_evt;
        set_vec[BIT_SLP] = slp_evt;
    end

    pm1_lane_decode u_dec (
        .wr_stb    (wr_stb),
        .offset    (acc_offset),
        .size      (acc_size),
        .wdata     (acc_wdata),
        .lane_we   (lane_we),
        .lane_byte (lane_byte)
    );

    pm1_status_reg u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (lane_we[REG_BYTES-1:0]),
        .clr_byte (lane_byte[REG_BYTES-1:0]),
        .set_vec  (set_vec),
        .sts_q    (sts_q)
    );

    pm1_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_we   (lane_we[LANES-1:REG_BYTES]),
        .wr_byte (lane_byte[LANES-1:REG_BYTES]),
        .en_q    (en_q)
    );

    pm1_read_mux u_rd (
        .sts     (sts_q),
        .en      (en_q),
        .offset  (acc_offset),
        .size    (acc_size),
        .rd_data (rd_data)
    );

    assign sci_level = |(en_q & sts_q & SCI_MASK);

    // R2
    sci_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci_level) |-> $past(wr_stb || (|set_vec)));

    // R2
    sci_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci_level) |-> $past(wr_stb));

    // R10
    no_lane_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (lane_we == '0));

    // R6
    top_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_offset == 2'd3) |-> (lane_we == (LANES'(1) << (LANES-1))));
endmodule

// File: tb/pm1_evt_regs_test.sv
`timescale 1ns/1ps
module pm1_evt_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        tmr_evt = 1'b0;
    logic        pwr_evt = 1'b0;
    logic        slp_evt = 1'b0;
    logic [31:0] rd_data;
    logic        sci_level;

    always #2 clk = ~clk;

    pm1_evt_regs uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .tmr_evt(tmr_evt), .pwr_evt(pwr_evt), .slp_evt(slp_evt),
        .rd_data(rd_data), .sci_level(sci_level)
    );

    typedef struct {
        bit          is_sci;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sample_ev;
    int       n_chk = 0;
    int       n_bad = 0;
    bit       done = 1'b0;

    logic [15:0] m_sts = '0;
    logic [15:0] m_en  = '0;

    function automatic logic [31:0] m_read(input logic [1:0] off, input logic [1:0] sz);
        logic [31:0] w;
        w = {m_en, m_sts} >> (8 * off);
        if (sz == 2'b00) w = w & 32'h0000_00FF;
        else if (sz == 2'b01) w = w & 32'h0000_FFFF;
        return w;
    endfunction

    // monitor: pops expectations and compares against the outputs
    always begin
        @(sample_ev);
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] got;
            it  = sb_q.pop_front();
            got = it.is_sci ? {31'b0, sci_level} : rd_data;
            n_chk++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s %s: got %h expected %h", it.tag,
                         it.is_sci ? "sci" : "rd", got, it.exp);
            end
        end
    end

    task automatic drive(input logic v, input logic w, input logic [1:0] off,
                         input logic [1:0] sz, input logic [31:0] d,
                         input logic t, input logic p, input logic s);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_offset = off; acc_size = sz;
        acc_wdata = d; tmr_evt = t; pwr_evt = p; slp_evt = s;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0; tmr_evt = 1'b0;
        pwr_evt = 1'b0; slp_evt = 1'b0;
        if (v && w) begin
            int nb;
            nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            for (int i = 0; i < nb; i++) begin
                int a;
                logic [7:0] b;
                a = int'(off) + i;
                b = d[8*i +: 8];
                case (a)
                    0: m_sts = m_sts & ~{8'h00, b};
                    1: m_sts = m_sts & ~{b, 8'h00};
                    2: m_en[7:0]  = b;
                    3: m_en[15:8] = b;
                    default: ;
                endcase
            end
        end
        if (t) m_sts[0] = 1'b1;
        if (p) m_sts[8] = 1'b1;
        if (s) m_sts[9] = 1'b1;
    endtask

    task automatic chk(input logic [1:0] off, input logic [1:0] sz, input string tag);
        sb_item_t a;
        sb_item_t b;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_offset = off; acc_size = sz;
        #1;
        a.is_sci = 1'b0; a.exp = m_read(off, sz); a.tag = tag;
        b.is_sci = 1'b1; b.exp = {31'b0, |(m_en & m_sts & 16'h0321)}; b.tag = tag;
        sb_q.push_back(a);
        sb_q.push_back(b);
        ->sample_ev;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_sts = '0; m_en = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(2'd0, 2'b10, "R9 reset state");
        rst_n = 1'b1;
        chk(2'd0, 2'b10, "R9 after release");

        drive(0, 0, 0, 0, 0, 0, 1, 0);
        chk(2'd1, 2'b00, "R1 power sets bit8");

        drive(1, 1, 2'd2, 2'b01, 32'h0000_0100, 0, 0, 0);
        chk(2'd2, 2'b01, "R5 R2 enable bit8 raises sci");

        drive(1, 1, 2'd0, 2'b01, 32'h0000_0000, 0, 0, 0);
        chk(2'd0, 2'b10, "R3 zero write keeps status");

        drive(1, 1, 2'd1, 2'b00, 32'h0000_0001, 0, 0, 0);
        chk(2'd0, 2'b10, "R3 clear bit8 drops sci");

        drive(0, 0, 0, 0, 0, 1, 0, 1);
        chk(2'd0, 2'b01, "R1 timer and sleep bits");

        drive(1, 1, 2'd0, 2'b10, 32'h0003_0001, 0, 0, 0);
        chk(2'd0, 2'b10, "R6 four-byte write at offset 0");

        drive(1, 1, 2'd3, 2'b10, 32'hFFFF_FF02, 0, 0, 0);
        chk(2'd0, 2'b10, "R6 bytes past offset 3 dropped");

        drive(1, 1, 2'd1, 2'b01, 32'h0000_C302, 0, 0, 0);
        chk(2'd2, 2'b01, "R6 straddling write lanes");
        chk(2'd1, 2'b00, "R3 straddle cleared bit9");

        drive(1, 1, 2'd1, 2'b11, 32'hFFFF_FFFF, 0, 0, 1);
        chk(2'd0, 2'b10, "R8 event beats clear");

        drive(1, 0, 2'd0, 2'b10, 32'hFFFF_FFFF, 0, 0, 0);
        drive(0, 1, 2'd0, 2'b10, 32'hFFFF_FFFF, 0, 0, 0);
        chk(2'd0, 2'b10, "R10 read and idle write ignored");

        drive(1, 1, 2'd2, 2'b01, 32'h0000_0020, 1, 0, 0);
        chk(2'd0, 2'b10, "R2 global enable masks timer");
        drive(1, 1, 2'd2, 2'b00, 32'h0000_0001, 0, 0, 0);
        chk(2'd0, 2'b10, "R2 timer enable raises sci");

        chk(2'd3, 2'b00, "R7 byte read offset 3");
        chk(2'd2, 2'b00, "R7 byte read offset 2");
        chk(2'd1, 2'b01, "R7 half read offset 1");
        chk(2'd1, 2'b10, "R7 word read offset 1");
        chk(2'd0, 2'b11, "R7 R6 size 11 is word");

        do_reset();
        chk(2'd0, 2'b10, "R9 mid-run reset");

        @(negedge clk);
        ->sample_ev;
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule